// File: doc/BRIEF.md
# Host-side sequencer for a self-calibrating successive-approximation converter

This block sits between on-chip logic and an external 13-bit successive-approximation converter that talks over an 8-bit parallel bus. On a one-cycle request it either pulses the converter's calibrate line or starts a conversion with the write strobe. A conversion runs with the converter's offset-nulling (auto-zero) mode either on or off. The block then waits for the converter's active-low interrupt and fetches the result as two bytes, upper byte first. It widens the 13-bit signed value to 16 bits and offers it on a valid/ready output.

Every strobe width, every gap between strobes and the interrupt wait limit are counted in system clocks and set by parameters. The defaults meet the converter's minimum pulse widths at a 50 MHz system clock. The interrupt line passes through a synchronizer, and its falling edge marks completion. If that edge does not come within the wait limit, the block flags a timeout and goes back to idle. A one-entry output register holds the last result. A new conversion is not accepted until the consumer has taken that result.

Top module: `adcx_host_ctrl`

## Requirements
- R1: During and after reset, adc_cs_n, adc_wr_n, adc_rd_n and adc_cal_n are 1, while busy, res_valid, timeout_err and adc_az are 0.
- R2: A cal_req accepted in idle drives adc_cal_n low for exactly CAL_LOW_CYC clocks, with adc_cs_n, adc_wr_n and adc_rd_n held high. busy stays 1 until the interrupt falls, and no write strobe is issued in that time.
- R3: When cal_req and start_req are both high in the same idle cycle, only the calibration is performed. The start request is dropped and produces no write strobe.
- R4: A start_req accepted in idle while res_valid is 0 drives adc_cs_n and adc_wr_n low together for exactly WR_LOW_CYC clocks. adc_az takes the value of az_en sampled with the request (1 means auto-zero on) and stays stable while busy is 1.
- R5: After the interrupt falls during a conversion, two read pulses follow. Each holds adc_rd_n low for exactly RD_LOW_CYC clocks, the two are separated by RD_GAP_CYC clocks high, and adc_cs_n is low whenever adc_rd_n is low.
- R6: The first byte read is the upper byte U and the second is the lower byte L. res_data equals the 13-bit value {U[4:0], L} sign-extended from U[4] to 16 bits.
- R7: res_fmt_err is 1 together with a result exactly when U[7:5] is not equal to three copies of U[4].
- R8: res_valid rises when the second read completes. res_valid, res_data and res_fmt_err then hold until a cycle with res_ready high. A start_req while res_valid is 1 is ignored and produces no write strobe.
- R9: If the interrupt does not fall within TIMEOUT_CYC clocks after a strobe phase ends, timeout_err becomes 1 and busy returns to 0, with no read strobe and no new result. timeout_err clears on the next accepted request.
- R10: Requests that arrive while busy is 1 are ignored and cause no further calibrate or write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_req | input | 1 | One-cycle request for a calibration cycle |
| start_req | input | 1 | One-cycle request for a conversion |
| az_en | input | 1 | Auto-zero choice for the requested conversion (1 = on) |
| busy | output | 1 | An operation is in progress |
| timeout_err | output | 1 | Last operation ended without an interrupt |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_wr_n | output | 1 | Converter write/start strobe, active low |
| adc_rd_n | output | 1 | Converter read strobe, active low |
| adc_cal_n | output | 1 | Converter calibrate line, active low |
| adc_az | output | 1 | Converter auto-zero select |
| adc_int_n | input | 1 | Converter interrupt, active low, asynchronous |
| adc_data | input | BUS_W | Converter data bus |
| res_valid | output | 1 | Output register holds a result |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | OUT_W | Sign-extended result |
| res_fmt_err | output | 1 | Upper byte was not a proper sign extension |

## Verification
A sequencer stuck in a wrong state shows at the strobe pins within one phase. Depending on the fault, a pulse comes out longer or shorter than its parameter, a write appears during a calibration, or a read appears without chip select. A byte captured in the wrong read slot, or a mis-shifted sign bit, shows on res_data as soon as res_valid rises for that conversion. A broken handshake or timeout path shows either as an overwritten or dropped result, or as busy staying high past the wait limit. The mix of random byte pairs and directed extremes (largest positive value, most negative value, all ones and malformed upper bytes) exercises every bit of the widening and of the format check.

// File: rtl/adcx_pkg.sv
package adcx_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CAL_LO,
    ST_CAL_WAIT,
    ST_WR_LO,
    ST_CONV_WAIT,
    ST_RD_HI,
    ST_RD_GAP,
    ST_RD_LO
  } adcx_state_e;

  function automatic int adcx_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adcx_sync_fall.sv
module adcx_sync_fall #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic fall
);

  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '1;
    else     sh <= {sh[STAGES-1:0], din};
  end

  assign fall = sh[STAGES] & ~sh[STAGES-1];

endmodule

// File: rtl/adcx_phase_timer.sv
module adcx_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // R5: strobe widths rely on a steady one-per-clock count
  p_count_down_r5: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/adcx_result_reg.sv
module adcx_result_reg #(
  parameter int BUS_W    = 8,
  parameter int SIGN_POS = 4,
  parameter int OUT_W    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BUS_W-1:0] bus_in,
  input  logic             cap_hi,
  input  logic             commit,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data,
  output logic             out_fmt_err
);

  localparam int VAL_W = BUS_W + SIGN_POS + 1;
  localparam int EXT_W = OUT_W - VAL_W;
  localparam int TOP_W = BUS_W - SIGN_POS;

  logic [BUS_W-1:0] hi_q;
  logic [TOP_W-1:0] top_slice;
  logic             top_ok;

  assign top_slice = hi_q[BUS_W-1:SIGN_POS];
  assign top_ok    = (&top_slice) | (~|top_slice);

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q        <= '0;
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_fmt_err <= 1'b0;
    end else begin
      if (cap_hi) hi_q <= bus_in;
      if (commit) begin
        out_valid   <= 1'b1;
        out_data    <= {{EXT_W{hi_q[SIGN_POS]}}, hi_q[SIGN_POS:0], bus_in};
        out_fmt_err <= ~top_ok;
      end else if (out_valid && out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R8: a result is never overwritten before it is taken
  p_no_overwrite_r8: assert property (@(posedge clk) disable iff (rst)
    commit |-> !out_valid);

  // R8: an untaken result stays put
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_fmt_err)));

endmodule

// File: rtl/adcx_host_ctrl.sv
module adcx_host_ctrl #(
  parameter int BUS_W       = 8,
  parameter int SIGN_POS    = 4,
  parameter int OUT_W       = 16,
  parameter int CAL_LOW_CYC = 12,
  parameter int WR_LOW_CYC  = 12,
  parameter int RD_LOW_CYC  = 6,
  parameter int RD_GAP_CYC  = 4,
  parameter int TIMEOUT_CYC = 32000,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cal_req,
  input  logic             start_req,
  input  logic             az_en,
  output logic             busy,
  output logic             timeout_err,
  output logic             adc_cs_n,
  output logic             adc_wr_n,
  output logic             adc_rd_n,
  output logic             adc_cal_n,
  output logic             adc_az,
  input  logic             adc_int_n,
  input  logic [BUS_W-1:0] adc_data,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [OUT_W-1:0] res_data,
  output logic             res_fmt_err
);

  import adcx_pkg::*;

  localparam int STROBE_MAX = adcx_max(adcx_max(CAL_LOW_CYC, WR_LOW_CYC),
                                       adcx_max(RD_LOW_CYC, RD_GAP_CYC));
  localparam int ALL_MAX    = adcx_max(STROBE_MAX, TIMEOUT_CYC);
  localparam int CNT_W      = $clog2(ALL_MAX + 1);

  localparam logic [CNT_W-1:0] CAL_LD = CNT_W'(CAL_LOW_CYC - 1);
  localparam logic [CNT_W-1:0] WR_LD  = CNT_W'(WR_LOW_CYC - 1);
  localparam logic [CNT_W-1:0] RD_LD  = CNT_W'(RD_LOW_CYC - 1);
  localparam logic [CNT_W-1:0] GAP_LD = CNT_W'(RD_GAP_CYC - 1);
  localparam logic [CNT_W-1:0] TO_LD  = CNT_W'(TIMEOUT_CYC - 1);

  adcx_state_e      state, state_nx;
  logic             t_load, t_zero;
  logic [CNT_W-1:0] t_val;
  logic             int_fall;
  logic             cap_hi, commit, to_set;
  logic             acc_cal, acc_conv;

  adcx_sync_fall #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (adc_int_n),
    .fall (int_fall)
  );

  adcx_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .zero     (t_zero)
  );

  adcx_result_reg #(.BUS_W(BUS_W), .SIGN_POS(SIGN_POS), .OUT_W(OUT_W)) u_res (
    .clk         (clk),
    .rst         (rst),
    .bus_in      (adc_data),
    .cap_hi      (cap_hi),
    .commit      (commit),
    .out_ready   (res_ready),
    .out_valid   (res_valid),
    .out_data    (res_data),
    .out_fmt_err (res_fmt_err)
  );

  always_comb begin
    state_nx = state;
    t_load   = 1'b0;
    t_val    = '0;
    cap_hi   = 1'b0;
    commit   = 1'b0;
    to_set   = 1'b0;
    acc_cal  = 1'b0;
    acc_conv = 1'b0;
    case (state)
      ST_IDLE: begin
        if (cal_req) begin
          acc_cal  = 1'b1;
          state_nx = ST_CAL_LO;
          t_load   = 1'b1;
          t_val    = CAL_LD;
        end else if (start_req && !res_valid) begin
          acc_conv = 1'b1;
          state_nx = ST_WR_LO;
          t_load   = 1'b1;
          t_val    = WR_LD;
        end
      end
      ST_CAL_LO: if (t_zero) begin
        state_nx = ST_CAL_WAIT;
        t_load   = 1'b1;
        t_val    = TO_LD;
      end
      ST_CAL_WAIT: begin
        if (int_fall) state_nx = ST_IDLE;
        else if (t_zero) begin
          state_nx = ST_IDLE;
          to_set   = 1'b1;
        end
      end
      ST_WR_LO: if (t_zero) begin
        state_nx = ST_CONV_WAIT;
        t_load   = 1'b1;
        t_val    = TO_LD;
      end
      ST_CONV_WAIT: begin
        if (int_fall) begin
          state_nx = ST_RD_HI;
          t_load   = 1'b1;
          t_val    = RD_LD;
        end else if (t_zero) begin
          state_nx = ST_IDLE;
          to_set   = 1'b1;
        end
      end
      ST_RD_HI: if (t_zero) begin
        cap_hi   = 1'b1;
        state_nx = ST_RD_GAP;
        t_load   = 1'b1;
        t_val    = GAP_LD;
      end
      ST_RD_GAP: if (t_zero) begin
        state_nx = ST_RD_LO;
        t_load   = 1'b1;
        t_val    = RD_LD;
      end
      ST_RD_LO: if (t_zero) begin
        commit   = 1'b1;
        state_nx = ST_IDLE;
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      busy        <= 1'b0;
      timeout_err <= 1'b0;
      adc_cs_n    <= 1'b1;
      adc_wr_n    <= 1'b1;
      adc_rd_n    <= 1'b1;
      adc_cal_n   <= 1'b1;
      adc_az      <= 1'b0;
    end else begin
      state     <= state_nx;
      busy      <= (state_nx != ST_IDLE);
      adc_cs_n  <= !(state_nx == ST_WR_LO || state_nx == ST_RD_HI ||
                     state_nx == ST_RD_GAP || state_nx == ST_RD_LO);
      adc_wr_n  <= (state_nx != ST_WR_LO);
      adc_rd_n  <= !(state_nx == ST_RD_HI || state_nx == ST_RD_LO);
      adc_cal_n <= (state_nx != ST_CAL_LO);
      if (acc_conv) adc_az <= az_en;
      if (to_set) timeout_err <= 1'b1;
      else if (acc_cal || acc_conv) timeout_err <= 1'b0;
    end
  end

  // R4: the write strobe only occurs with chip select
  p_wr_with_cs_r4: assert property (@(posedge clk) disable iff (rst)
    !adc_wr_n |-> !adc_cs_n);

  // R4: auto-zero select is frozen for the whole operation
  p_az_stable_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(adc_az));

  // R5: reads overlap neither write nor calibrate
  p_rd_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !adc_rd_n |-> (adc_wr_n && adc_cal_n && !adc_cs_n));

  // R2: calibration runs without chip select
  p_cal_no_cs_r2: assert property (@(posedge clk) disable iff (rst)
    !adc_cal_n |-> (adc_cs_n && adc_wr_n));

  // R9: a timeout always leaves the block idle
  p_timeout_idle_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout_err) |-> !busy);

endmodule

// File: tb/sim_adcx_host_ctrl.sv
module sim_adcx_host_ctrl;

  localparam int CAL_W = 12, WR_W = 12, RD_W = 6, GAP_W = 4, TO_C = 600;
  localparam int CAL_T = 200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cal_req = 1'b0, start_req = 1'b0, az_en = 1'b0, res_ready = 1'b0;
  logic busy, timeout_err, adc_cs_n, adc_wr_n, adc_rd_n, adc_cal_n, adc_az;
  logic adc_int_n = 1'b1;
  logic [7:0] adc_data = 8'h00;
  logic res_valid, res_fmt_err;
  logic [15:0] res_data;

  always #10 clk = ~clk;

  adcx_host_ctrl #(
    .CAL_LOW_CYC(CAL_W), .WR_LOW_CYC(WR_W), .RD_LOW_CYC(RD_W),
    .RD_GAP_CYC(GAP_W), .TIMEOUT_CYC(TO_C)
  ) u0 (
    .clk(clk), .rst(rst), .cal_req(cal_req), .start_req(start_req), .az_en(az_en),
    .busy(busy), .timeout_err(timeout_err), .adc_cs_n(adc_cs_n), .adc_wr_n(adc_wr_n),
    .adc_rd_n(adc_rd_n), .adc_cal_n(adc_cal_n), .adc_az(adc_az), .adc_int_n(adc_int_n),
    .adc_data(adc_data), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .res_fmt_err(res_fmt_err)
  );

  // behavioural converter
  logic [7:0] m_hi = 8'h00, m_lo = 8'h00;
  logic mute = 1'b0, az_seen = 1'b0, ptr = 1'b0;
  logic p_cal = 1'b1, p_wr = 1'b1, p_rd = 1'b1;
  int   mcnt = 0;

  always @(posedge clk) begin
    p_cal <= adc_cal_n; p_wr <= adc_wr_n; p_rd <= adc_rd_n;
    if (rst) begin
      adc_int_n <= 1'b1; mcnt <= 0; ptr <= 1'b0;
    end else begin
      if (p_cal && !adc_cal_n) adc_int_n <= 1'b1;
      if (p_wr && !adc_wr_n) adc_int_n <= 1'b1;
      if (!p_cal && adc_cal_n) mcnt <= CAL_T;
      else if (!p_wr && adc_wr_n) begin
        mcnt <= adc_az ? 34*3 : 27*3;
        az_seen <= adc_az;
      end else if (mcnt != 0) begin
        mcnt <= mcnt - 1;
        if (mcnt == 1 && !mute) begin adc_int_n <= 1'b0; ptr <= 1'b0; end
      end
      if (p_rd && !adc_rd_n) begin
        adc_int_n <= 1'b1;
        adc_data <= ptr ? m_lo : m_hi;
        ptr <= 1'b1;
      end
    end
  end

  // strobe monitor
  int wr_run = 0, cal_run = 0, rd_run = 0, gap_run = 0;
  int last_wr_w = 0, last_cal_w = 0, last_rd_w = 0, prev_rd_w = 0, last_gap = 0;
  int n_wr = 0, n_cal = 0, n_rd = 0, cs_bad = 0;

  always @(negedge clk) begin
    if (!adc_wr_n) wr_run++;
    else if (wr_run != 0) begin last_wr_w = wr_run; wr_run = 0; n_wr++; end
    if (!adc_cal_n) cal_run++;
    else if (cal_run != 0) begin last_cal_w = cal_run; cal_run = 0; n_cal++; end
    if (!adc_rd_n) begin
      if (gap_run != 0) begin last_gap = gap_run; gap_run = 0; end
      rd_run++;
    end else begin
      if (rd_run != 0) begin prev_rd_w = last_rd_w; last_rd_w = rd_run; rd_run = 0; n_rd++; end
      if (!adc_cs_n) gap_run++; else gap_run = 0;
    end
    if ((!adc_rd_n || !adc_wr_n) && adc_cs_n) cs_bad++;
  end

  int errors = 0, checks = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_res(input logic [7:0] u, input logic [7:0] l);
    return {{3{u[4]}}, u[4:0], l};
  endfunction

  function automatic logic exp_fmt(input logic [7:0] u);
    return u[7:5] != {3{u[4]}};
  endfunction

  task automatic pulse(input bit c, input bit s, input bit az);
    @(negedge clk);
    cal_req = c; start_req = s; az_en = az;
    @(negedge clk);
    cal_req = 1'b0; start_req = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic take();
    @(negedge clk); res_ready = 1'b1;
    @(negedge clk); res_ready = 1'b0;
    chk(res_valid == 1'b0, "R8 taken", int'(res_valid), 0);
  endtask

  task automatic conv(input bit az, input logic [7:0] u, input logic [7:0] l);
    int wr0, rd0;
    m_hi = u; m_lo = l;
    wr0 = n_wr; rd0 = n_rd;
    pulse(1'b0, 1'b1, az);
    wait_idle();
    @(negedge clk);
    chk(n_wr == wr0 + 1 && last_wr_w == WR_W, "R4 wr width", last_wr_w, WR_W);
    chk(az_seen == az, "R4 az", int'(az_seen), int'(az));
    chk(n_rd == rd0 + 2 && last_rd_w == RD_W && prev_rd_w == RD_W,
        "R5 rd widths", last_rd_w * 256 + prev_rd_w, RD_W * 257);
    chk(last_gap == GAP_W && cs_bad == 0, "R5 gap/cs", last_gap, GAP_W);
    chk(res_valid == 1'b1, "R8 valid", int'(res_valid), 1);
    chk(res_data == exp_res(u, l), "R6 data", int'(res_data), int'(exp_res(u, l)));
    chk(res_fmt_err == exp_fmt(u), "R7 fmt", int'(res_fmt_err), int'(exp_fmt(u)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R10 watchdog act=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int c0, w0, r0;
    logic [7:0] u, l;
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    chk(adc_cs_n && adc_wr_n && adc_rd_n && adc_cal_n, "R1 strobes in reset",
        {adc_cs_n, adc_wr_n, adc_rd_n, adc_cal_n}, 4'hF);
    chk(!busy && !res_valid && !timeout_err && !adc_az, "R1 flags in reset",
        {busy, res_valid, timeout_err, adc_az}, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(adc_cs_n && adc_wr_n && adc_rd_n && adc_cal_n && !busy && !res_valid,
        "R1 after reset", {adc_cs_n, adc_wr_n, adc_rd_n, adc_cal_n, busy, res_valid}, 6'h3C);

    // R2 calibration
    pulse(1'b1, 1'b0, 1'b0);
    chk(busy == 1'b1, "R2 busy", int'(busy), 1);
    wait_idle();
    @(negedge clk);
    chk(n_cal == 1 && last_cal_w == CAL_W, "R2 cal width", last_cal_w, CAL_W);
    chk(n_wr == 0 && !timeout_err, "R2 no write", n_wr, 0);

    // R3 simultaneous requests
    c0 = n_cal; w0 = n_wr;
    pulse(1'b1, 1'b1, 1'b1);
    wait_idle();
    @(negedge clk);
    chk(n_cal == c0 + 1 && n_wr == w0, "R3 cal wins", n_wr - w0, 0);

    // directed corner values
    conv(1'b1, 8'h0F, 8'hFF); take();
    conv(1'b0, 8'hF0, 8'h00); take();
    conv(1'b1, 8'hFF, 8'hFF); take();
    conv(1'b0, 8'h00, 8'h00); take();
    conv(1'b1, 8'h1F, 8'h5A); take();
    conv(1'b0, 8'h80, 8'hA5); take();

    // random traffic
    for (int i = 0; i < 20; i++) begin
      l = 8'($urandom);
      u = 8'($urandom);
      if (u[0]) u[7:5] = {3{u[4]}};
      conv(1'($urandom), u, l);
      take();
    end

    // R8 hold and blocked start
    conv(1'b0, 8'h03, 8'h21);
    repeat (20) @(negedge clk);
    chk(res_valid && res_data == 16'h0321, "R8 hold", int'(res_data), 16'h0321);
    w0 = n_wr;
    pulse(1'b0, 1'b1, 1'b1);
    repeat (300) @(negedge clk);
    chk(n_wr == w0 && !busy && res_data == 16'h0321, "R8 start blocked", n_wr - w0, 0);
    take();

    // R10 requests during busy
    c0 = n_cal; w0 = n_wr;
    m_hi = 8'hF8; m_lo = 8'h01;
    pulse(1'b0, 1'b1, 1'b0);
    repeat (5) @(negedge clk);
    pulse(1'b1, 1'b1, 1'b1);
    repeat (30) @(negedge clk);
    pulse(1'b1, 1'b0, 1'b1);
    wait_idle();
    repeat (3) @(negedge clk);
    chk(n_cal == c0 && n_wr == w0 + 1 && !busy, "R10 ignored", n_cal - c0, 0);
    chk(res_data == 16'hF801 && az_seen == 1'b0, "R10 data", int'(res_data), 16'hF801);
    take();

    // R9 timeout
    mute = 1'b1;
    r0 = n_rd;
    pulse(1'b0, 1'b1, 1'b1);
    repeat (TO_C - 50) @(negedge clk);
    chk(busy && !timeout_err, "R9 still waiting", int'(busy), 1);
    repeat (200) @(negedge clk);
    chk(timeout_err && !busy, "R9 timeout flag", int'(timeout_err), 1);
    chk(n_rd == r0 && !res_valid, "R9 no read", n_rd - r0, 0);
    mute = 1'b0;
    m_hi = 8'h07; m_lo = 8'h77;
    pulse(1'b0, 1'b1, 1'b0);
    chk(!timeout_err, "R9 cleared", int'(timeout_err), 0);
    wait_idle();
    @(negedge clk);
    chk(res_valid && res_data == 16'h0777, "R9 recovery", int'(res_data), 16'h0777);
    take();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule